// File: doc/BRIEF.md
# Dual Strobed Parallel Port with Interrupt Flags

This block provides two 8-bit general-purpose parallel ports, A and B. Each port has one strobe line. Each port runs either as an input or as an output. An input port holds a data latch whose clock is the synchronized strobe pin XOR a polarity bit. The latch is transparent while that clock is low. It freezes the pin values on the clock's rising edge, which is the trailing edge of the strobe pulse, and the same edge raises the port's interrupt flag. An output port drives its latch onto the pins. Every write to an output port's data register sends a fixed-length pulse on the strobe line, and the pulse's sense follows the polarity bit.

A processor-side register bus reaches six registers: a data register and a live pin register for each port, a status register, and a configuration register. The status register holds the port flags, the interrupt enables and an end-of-write flag. That flag is set by an external input. The block drives an active-low interrupt request while any pending flag has its enable set. The configuration register picks the flag clearing rule: either reading the port's data register clears the flag, or software writes 0 to the flag bit. Flipping a polarity bit with the strobe held still gives a software-generated capture and interrupt.

Top module: `strobe_port_pair`

## Requirements
- R1: After reset the configuration register reads 0x40, the status register reads 0x00, irq_n is high, and all pin and strobe output enables are low.
- R2: reg_sel selects the register: 0 port A data, 1 port B data, 2 port A pins, 3 port B pins, 4 status, 5 configuration. Any other value reads 0x00. Configuration bits, from bit 7 down: clear mode, constant 1, A open-drain, B open-drain, A output (1 = output), B output, A polarity, B polarity. Bit 6 always reads 1. The open-drain bits appear on a_od and b_od.
- R3: For an input port the latch clock is the synchronized strobe XOR the polarity bit. The data register follows the pins while that clock is low and holds the pins present at its rising edge. Later pin changes do not alter it while the clock stays high.
- R4: A capture sets the port flag (status bit 6 for A, bit 5 for B). Status bit 7 reads as the OR of the two port flags. Status bit 1 reads 0.
- R5: irq_n is low exactly while a set flag has its enable set: A flag with bit 4, B flag with bit 3, end-of-write bit 0 with bit 2. This includes an enable written after its flag is already pending.
- R6: With clear mode 0, a read of a port's data register clears that port's flag. Writes to the flag bits have no effect.
- R7: With clear mode 1, writing 0 to a port flag bit clears it. Writing 1 leaves it unchanged, and reading the data register does not clear it.
- R8: Writing an output port's data register drives the value on its pins from the next cycle, with every output enable high. It also drives the strobe to the polarity bit's value for PULSE_W cycles (default 4). The strobe idles at the inverse of that bit.
- R9: A port in output mode never sets its flag, whatever its strobe input does.
- R10: The pin register returns the synchronized pin values in either mode. In open-drain output mode the output enable is high only for data bits that are 0.
- R11: Inverting a polarity bit while the strobe input is steady produces a rising latch clock, which captures the pins and sets the flag.
- R12: eow_in high sets status bit 0. Software clears it by writing 0 there. When a set event and a clear fall in the same cycle, the flag ends up set, for both the end-of-write flag and the port flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| eow_in | input | 1 | End-of-write event |
| a_pin_i | input | 8 | Port A pin levels |
| a_pin_o | output | 8 | Port A pin drive data |
| a_pin_oe | output | 8 | Port A per-pin output enable |
| a_od | output | 1 | Port A open-drain mode |
| a_stb_i | input | 1 | Port A strobe pin level |
| a_stb_o | output | 1 | Port A strobe drive value |
| a_stb_oe | output | 1 | Port A strobe output enable |
| b_pin_i | input | 8 | Port B pin levels |
| b_pin_o | output | 8 | Port B pin drive data |
| b_pin_oe | output | 8 | Port B per-pin output enable |
| b_od | output | 1 | Port B open-drain mode |
| b_stb_i | input | 1 | Port B strobe pin level |
| b_stb_o | output | 1 | Port B strobe drive value |
| b_stb_oe | output | 1 | Port B strobe output enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag can be set and cleared in the same clock cycle. The bench forces this in two ways. In the first, it rewrites the configuration to flip port B's polarity with the strobe held still, which raises a capture exactly one edge later. On that next edge it issues a status write of 0 under clear mode 1. In the second, it holds eow_in high during the cycle in which status bit 0 is written to 0. In both cases the flag must read back as set afterwards. The bench also checks a late enable, an output-mode strobe that must be ignored, and the polarity-toggle capture.

// File: rtl/spp_pkg.sv
package spp_pkg;

    localparam int REG_W = 8;
    localparam int NPORT = 2;

    typedef enum logic [2:0] {
        SEL_DATA_A = 3'd0,
        SEL_DATA_B = 3'd1,
        SEL_PIN_A  = 3'd2,
        SEL_PIN_B  = 3'd3,
        SEL_STAT   = 3'd4,
        SEL_CFG    = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic irst;
        logic one;
        logic od_a;
        logic od_b;
        logic out_a;
        logic out_b;
        logic pol_a;
        logic pol_b;
    } cfg_t;

    typedef struct packed {
        logic fa;
        logic fb;
        logic en_a;
        logic en_b;
        logic en_eow;
        logic eow;
    } stat_t;

    localparam logic [REG_W-1:0] CFG_RST = 8'h40;

endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
    parameter int         W       = 8,
    parameter logic [0:0] RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= {W{RST_VAL}};
            s2_q <= {W{RST_VAL}};
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/spp_port.sv
module spp_port #(
    parameter int W       = 8,
    parameter int PULSE_W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         out_mode,
    input  logic         pol,
    input  logic         od,
    input  logic         wr_data,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_i,
    input  logic         stb_i,
    output logic [W-1:0] data_o,
    output logic [W-1:0] pin_sync_o,
    output logic         capture_o,
    output logic [W-1:0] pin_o,
    output logic [W-1:0] pin_oe,
    output logic         stb_o,
    output logic         stb_oe
);
    localparam int CW = $clog2(PULSE_W + 1);

    typedef struct packed {
        logic [W-1:0]  data;
        logic          clk_prev;
        logic [CW-1:0] cnt;
    } port_st_t;

    port_st_t st_d, st_q;
    logic [W-1:0] pin_s;
    logic         stb_s;
    logic         lclk, rise, pulse_on;

    spp_sync #(.W(W), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
    );
    spp_sync #(.W(1), .RST_VAL(1'b1)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .d(stb_i), .q(stb_s)
    );

    assign lclk     = stb_s ^ pol;
    assign rise     = lclk & ~st_q.clk_prev;
    assign pulse_on = (st_q.cnt != '0);

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = lclk;
        if (pulse_on) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        if (out_mode) begin
            if (wr_data) begin
                st_d.data = wdata;
                st_d.cnt  = CW'(PULSE_W);
            end
        end else if (!lclk || rise) begin
            st_d.data = pin_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.data     <= '0;
            st_q.clk_prev <= 1'b1;
            st_q.cnt      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o     = st_q.data;
    assign pin_sync_o = pin_s;
    assign capture_o  = rise & ~out_mode;
    assign pin_o      = st_q.data;
    assign pin_oe     = out_mode ? (od ? ~st_q.data : {W{1'b1}}) : '0;
    assign stb_o      = pulse_on ? pol : ~pol;
    assign stb_oe     = out_mode;

    // R8
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_on) |-> $past(wr_data && out_mode));

    // R8
    out_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_data && out_mode) |-> (pin_o == $past(wdata)));
endmodule

// File: rtl/strobe_port_pair.sv
module strobe_port_pair
    import spp_pkg::*;
#(
    parameter int PULSE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             eow_in,
    input  logic [REG_W-1:0] a_pin_i,
    output logic [REG_W-1:0] a_pin_o,
    output logic [REG_W-1:0] a_pin_oe,
    output logic             a_od,
    input  logic             a_stb_i,
    output logic             a_stb_o,
    output logic             a_stb_oe,
    input  logic [REG_W-1:0] b_pin_i,
    output logic [REG_W-1:0] b_pin_o,
    output logic [REG_W-1:0] b_pin_oe,
    output logic             b_od,
    input  logic             b_stb_i,
    output logic             b_stb_o,
    output logic             b_stb_oe,
    output logic             irq_n
);
    typedef struct packed {
        cfg_t  cfg;
        stat_t st;
    } top_st_t;

    top_st_t q, d;

    logic             p_out   [NPORT];
    logic             p_pol   [NPORT];
    logic             p_od    [NPORT];
    logic             p_wr    [NPORT];
    logic [REG_W-1:0] p_pin_i [NPORT];
    logic             p_stb_i [NPORT];
    logic [REG_W-1:0] p_data  [NPORT];
    logic [REG_W-1:0] p_psync [NPORT];
    logic             p_cap   [NPORT];
    logic [REG_W-1:0] p_pin_o [NPORT];
    logic [REG_W-1:0] p_oe    [NPORT];
    logic             p_stb_o [NPORT];
    logic             p_stb_oe[NPORT];

    logic wr_stat, wr_cfg, rd_da, rd_db;

    assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
    assign wr_cfg  = reg_wr && (reg_sel == SEL_CFG);
    assign rd_da   = reg_rd && (reg_sel == SEL_DATA_A);
    assign rd_db   = reg_rd && (reg_sel == SEL_DATA_B);

    assign p_out[0]   = q.cfg.out_a;
    assign p_out[1]   = q.cfg.out_b;
    assign p_pol[0]   = q.cfg.pol_a;
    assign p_pol[1]   = q.cfg.pol_b;
    assign p_od[0]    = q.cfg.od_a;
    assign p_od[1]    = q.cfg.od_b;
    assign p_wr[0]    = reg_wr && (reg_sel == SEL_DATA_A);
    assign p_wr[1]    = reg_wr && (reg_sel == SEL_DATA_B);
    assign p_pin_i[0] = a_pin_i;
    assign p_pin_i[1] = b_pin_i;
    assign p_stb_i[0] = a_stb_i;
    assign p_stb_i[1] = b_stb_i;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        spp_port #(.W(REG_W), .PULSE_W(PULSE_W)) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .out_mode   (p_out[i]),
            .pol        (p_pol[i]),
            .od         (p_od[i]),
            .wr_data    (p_wr[i]),
            .wdata      (reg_wdata),
            .pin_i      (p_pin_i[i]),
            .stb_i      (p_stb_i[i]),
            .data_o     (p_data[i]),
            .pin_sync_o (p_psync[i]),
            .capture_o  (p_cap[i]),
            .pin_o      (p_pin_o[i]),
            .pin_oe     (p_oe[i]),
            .stb_o      (p_stb_o[i]),
            .stb_oe     (p_stb_oe[i])
        );
    end

    assign a_pin_o  = p_pin_o[0];
    assign a_pin_oe = p_oe[0];
    assign a_stb_o  = p_stb_o[0];
    assign a_stb_oe = p_stb_oe[0];
    assign a_od     = q.cfg.od_a;
    assign b_pin_o  = p_pin_o[1];
    assign b_pin_oe = p_oe[1];
    assign b_stb_o  = p_stb_o[1];
    assign b_stb_oe = p_stb_oe[1];
    assign b_od     = q.cfg.od_b;

    always_comb begin
        logic sw_clr_a, sw_clr_b, rd_clr_a, rd_clr_b;
        d = q;
        sw_clr_a = wr_stat && q.cfg.irst && !reg_wdata[6];
        sw_clr_b = wr_stat && q.cfg.irst && !reg_wdata[5];
        rd_clr_a = rd_da && !q.cfg.irst;
        rd_clr_b = rd_db && !q.cfg.irst;
        if (wr_cfg) begin
            d.cfg     = cfg_t'(reg_wdata);
            d.cfg.one = 1'b1;
        end
        if (wr_stat) begin
            d.st.en_a   = reg_wdata[4];
            d.st.en_b   = reg_wdata[3];
            d.st.en_eow = reg_wdata[2];
        end
        d.st.fa  = p_cap[0] | (q.st.fa & ~sw_clr_a & ~rd_clr_a);
        d.st.fb  = p_cap[1] | (q.st.fb & ~sw_clr_b & ~rd_clr_b);
        d.st.eow = eow_in | (q.st.eow & ~(wr_stat && !reg_wdata[0]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg <= cfg_t'(CFG_RST);
            q.st  <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_DATA_A: reg_rdata = p_data[0];
            SEL_DATA_B: reg_rdata = p_data[1];
            SEL_PIN_A:  reg_rdata = p_psync[0];
            SEL_PIN_B:  reg_rdata = p_psync[1];
            SEL_STAT:   reg_rdata = {q.st.fa | q.st.fb, q.st.fa, q.st.fb, q.st.en_a,
                                     q.st.en_b, q.st.en_eow, 1'b0, q.st.eow};
            SEL_CFG:    reg_rdata = q.cfg;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_n = ~((q.st.fa & q.st.en_a) | (q.st.fb & q.st.en_b) |
                     (q.st.eow & q.st.en_eow));

    // R9
    out_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.cfg.out_a) && !$past(q.st.fa)) |-> !q.st.fa);

    // R5
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st.fa && q.st.en_a) || (q.st.fb && q.st.en_b)) |-> !irq_n);

    // R7
    irst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st.fa) && $past(q.cfg.irst) &&
         !$past(reg_wr && (reg_sel == SEL_STAT))) |-> q.st.fa);

    // R12
    eow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eow_in) |-> q.st.eow);
endmodule

// File: tb/strobe_port_pair_tb.sv
module strobe_port_pair_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic       eow_in = 1'b0;
    logic [7:0] a_pin_i = 8'h00, a_pin_o, a_pin_oe;
    logic [7:0] b_pin_i = 8'h00, b_pin_o, b_pin_oe;
    logic       a_od, b_od, a_stb_o, a_stb_oe, b_stb_o, b_stb_oe, irq_n;
    logic       a_stb_i = 1'b1, b_stb_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    strobe_port_pair #(.PULSE_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eow_in(eow_in),
        .a_pin_i(a_pin_i), .a_pin_o(a_pin_o), .a_pin_oe(a_pin_oe), .a_od(a_od),
        .a_stb_i(a_stb_i), .a_stb_o(a_stb_o), .a_stb_oe(a_stb_oe),
        .b_pin_i(b_pin_i), .b_pin_o(b_pin_o), .b_pin_oe(b_pin_oe), .b_od(b_od),
        .b_stb_i(b_stb_i), .b_stb_o(b_stb_o), .b_stb_oe(b_stb_oe),
        .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_a(input logic [7:0] v);
        a_pin_i = v; idle(3);
        a_stb_i = 1'b0; idle(4);
        a_stb_i = 1'b1; idle(4);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        idle(1);
        rd(3'd5, v); chk("R1 cfg reset", v, 8'h40);
        rd(3'd4, v); chk("R1 stat reset", v, 8'h00);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 a oe", a_pin_oe, 8'h00);
        chk("R1 b oe", b_pin_oe, 8'h00);
        chk("R1 strobe oe", {6'd0, a_stb_oe, b_stb_oe}, 8'h00);
    endtask

    task automatic t_cfg;
        logic [7:0] v;
        wr(3'd5, 8'h30);
        rd(3'd5, v); chk("R2 cfg bit6 forced", v, 8'h70);
        chk("R2 od flags", {6'd0, a_od, b_od}, 8'h03);
        wr(3'd5, 8'h40);
        rd(3'd5, v); chk("R2 cfg restore", v, 8'h40);
        rd(3'd6, v); chk("R2 unused select", v, 8'h00);
    endtask

    task automatic t_capture;
        logic [7:0] v;
        a_pin_i = 8'hA5; idle(4);
        a_stb_i = 1'b0; idle(4);
        rd(3'd0, v); chk("R3 transparent", v, 8'hA5);
        a_pin_i = 8'h3C; idle(4);
        rd(3'd0, v); chk("R3 transparent follow", v, 8'h3C);
        a_stb_i = 1'b1; idle(4);
        a_pin_i = 8'hFF; idle(4);
        rd(3'd4, v); chk("R4 flag A and summary", v, 8'hC0);
        rd(3'd0, v); chk("R3 held after edge", v, 8'h3C);
        rd(3'd4, v); chk("R6 read clears flag", v, 8'h00);
    endtask

    task automatic t_late_enable;
        logic [7:0] v;
        b_pin_i = 8'h5E; idle(3);
        b_stb_i = 1'b0; idle(4);
        b_stb_i = 1'b1; idle(4);
        chk("R5 no irq while masked", {7'd0, irq_n}, 8'h01);
        rd(3'd4, v); chk("R4 flag B", v, 8'hA0);
        wr(3'd4, 8'h08);
        chk("R5 late enable irq", {7'd0, irq_n}, 8'h00);
        rd(3'd1, v); chk("R3 port B data", v, 8'h5E);
        chk("R5 irq released", {7'd0, irq_n}, 8'h01);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_irst0_write;
        logic [7:0] v;
        pulse_a(8'h42);
        wr(3'd4, 8'h00);
        rd(3'd4, v); chk("R6 write ignored", v, 8'hC0);
        rd(3'd0, v);
        rd(3'd4, v); chk("R6 cleared by read", v, 8'h00);
    endtask

    task automatic t_irst1;
        logic [7:0] v;
        wr(3'd5, 8'hC0);
        pulse_a(8'h11);
        rd(3'd0, v); chk("R7 data", v, 8'h11);
        rd(3'd4, v); chk("R7 read keeps flag", v, 8'hC0);
        wr(3'd4, 8'h40);
        rd(3'd4, v); chk("R7 write 1 keeps", v, 8'hC0);
        wr(3'd4, 8'h00);
        rd(3'd4, v); chk("R7 write 0 clears", v, 8'h00);
        wr(3'd5, 8'h40);
    endtask

    task automatic t_output;
        int cnt;
        wr(3'd5, 8'h48);
        wr(3'd4, 8'h10);
        chk("R8 strobe idle high", {6'd0, a_stb_oe, a_stb_o}, 8'h03);
        @(negedge clk);
        reg_sel = 3'd0; reg_wdata = 8'h5A; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        chk("R8 pins driven", a_pin_o, 8'h5A);
        chk("R8 all enabled", a_pin_oe, 8'hFF);
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            if (a_stb_o == 1'b0) cnt++;
            @(negedge clk);
        end
        chk("R8 low pulse width", 8'(cnt), 8'(PW));
        wr(3'd5, 8'h4A);
        chk("R8 idle low pol1", {7'd0, a_stb_o}, 8'h00);
        @(negedge clk);
        reg_sel = 3'd0; reg_wdata = 8'hC3; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            if (a_stb_o == 1'b1) cnt++;
            @(negedge clk);
        end
        chk("R8 high pulse width", 8'(cnt), 8'(PW));
        wr(3'd5, 8'h48);
    endtask

    task automatic t_out_noflag;
        logic [7:0] v;
        a_pin_i = 8'h0F;
        a_stb_i = 1'b0; idle(4);
        a_stb_i = 1'b1; idle(4);
        rd(3'd4, v); chk("R9 no flag in output", v, 8'h10);
        chk("R9 no irq", {7'd0, irq_n}, 8'h01);
        rd(3'd0, v); chk("R9 data kept", v, 8'hC3);
    endtask

    task automatic t_opendrain;
        logic [7:0] v;
        wr(3'd5, 8'h68);
        wr(3'd0, 8'hF0);
        chk("R10 od enables", a_pin_oe, 8'h0F);
        chk("R10 od flag", {7'd0, a_od}, 8'h01);
        a_pin_i = 8'h96; b_pin_i = 8'h69; idle(3);
        rd(3'd2, v); chk("R10 pin A live", v, 8'h96);
        rd(3'd3, v); chk("R10 pin B live", v, 8'h69);
        wr(3'd5, 8'h48);
        wr(3'd5, 8'h40);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_soft;
        logic [7:0] v;
        wr(3'd5, 8'h41);
        b_pin_i = 8'h77; idle(3);
        wr(3'd5, 8'h40);
        idle(1);
        rd(3'd4, v); chk("R11 polarity capture flag", v, 8'hA0);
        rd(3'd1, v); chk("R11 polarity capture data", v, 8'h77);
        rd(3'd4, v); chk("R11 cleared", v, 8'h00);
    endtask

    task automatic t_eow;
        logic [7:0] v;
        wr(3'd4, 8'h04);
        @(negedge clk); eow_in = 1'b1;
        @(negedge clk); eow_in = 1'b0;
        chk("R5 eow irq", {7'd0, irq_n}, 8'h00);
        rd(3'd4, v); chk("R12 eow set", v, 8'h05);
        wr(3'd4, 8'h05);
        rd(3'd4, v); chk("R12 write 1 keeps", v, 8'h05);
        wr(3'd4, 8'h04);
        rd(3'd4, v); chk("R12 write 0 clears", v, 8'h04);
        chk("R5 eow irq off", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_collide;
        logic [7:0] v;
        @(negedge clk);
        eow_in = 1'b1; reg_sel = 3'd4; reg_wdata = 8'h04; reg_wr = 1'b1;
        @(negedge clk);
        eow_in = 1'b0; reg_wr = 1'b0;
        rd(3'd4, v); chk("R12 eow set beats clear", v, 8'h05);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'hC1);
        idle(2);
        @(negedge clk);
        reg_sel = 3'd5; reg_wdata = 8'hC0; reg_wr = 1'b1;
        @(negedge clk);
        reg_sel = 3'd4; reg_wdata = 8'h00;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd4, v); chk("R12 capture beats clear", v, 8'hA0);
        wr(3'd4, 8'h00);
        rd(3'd4, v); chk("R7 cleared after collision", v, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_capture();
        t_late_enable();
        t_irst0_write();
        t_irst1();
        t_output();
        t_out_noflag();
        t_opendrain();
        t_soft();
        t_eow();
        t_collide();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule